// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block arbitrates sixteen level-sensitive hardware request lines and eight software-settable requests. Every source has a 4-bit priority that software programs. The controller presents the vector and priority of the most urgent pending source to the processor core. A request reaches the core only when its priority is strictly above the current priority mask.

The request to the core works as a valid/ready pair. `irq` is the valid signal, `irq_vector` and `irq_prio` form the payload, and `ack` is the ready signal. A transfer happens on a rising clock edge where `ack` and `irq` are both high. While `ack` stays low, the core holds back the transfer. During that time the payload can change: a more urgent source that arrives replaces the current winner, and `irq` drops if every request is withdrawn. The core must therefore take the payload in the same cycle as the transfer. An `ack` while `irq` is low does nothing.

When a transfer happens, the old mask is pushed onto an 8-entry LIFO and the mask rises to the serviced priority. Each end-of-interrupt pulse pops the LIFO. Software can also write the mask directly. This lets it raise the mask for priority-ceiling locking of a shared resource. A handler can set a lower-priority software request so that follow-up work runs after it finishes.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask is 0, all priorities are 0 and no software request is pending, so `irq` stays low even when all hardware lines are high.
- R2: A pending source with priority 0 never raises `irq`. `irq` is high exactly when the best pending priority is strictly greater than `cur_mask`.
- R3: The highest pending priority wins, and among equal priorities the lowest source index wins. Hardware line i gives vector i (0..15) and software request j gives vector 16+j (16..23).
- R4: A write with `cfg_we` stores `cfg_prio` for source `cfg_src` when `cfg_src` is below 24. A write to any higher index changes nothing.
- R5: A `mask_we` pulse loads `mask_wdata` into `cur_mask` on the next edge, unless a transfer or an end-of-interrupt takes place in the same cycle.
- R6: A transfer (`ack` with `irq` high) pushes `cur_mask` and sets `cur_mask` to `irq_prio` on that edge. An `ack` while `irq` is low leaves the mask unchanged.
- R7: An `eoi` pulse pops the most recent pushed value into `cur_mask`. An `eoi` on an empty LIFO sets `cur_mask` to 0.
- R8: The LIFO holds 8 entries. A push when the LIFO is full is discarded, while the mask still rises.
- R9: Writing 1 to a bit of `sw_set` makes that software request pending, and writing 1 to a bit of `sw_clr` clears it. If both bits are written in the same cycle, set wins.
- R10: In one cycle a transfer has precedence over `eoi`, and `eoi` has precedence over `mask_we`. The lower-precedence strobes in that cycle are ignored.
- R11: `irq`, `irq_vector` and `irq_prio` follow `hw_req` combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | 16 | Level-sensitive hardware requests |
| sw_set | input | 8 | Set pulses for software requests |
| sw_clr | input | 8 | Clear pulses for software requests |
| cfg_we | input | 1 | Priority write strobe |
| cfg_src | input | 5 | Source index for the priority write |
| cfg_prio | input | 4 | Priority value to write |
| mask_we | input | 1 | Direct mask write strobe |
| mask_wdata | input | 4 | Mask value to write |
| irq | output | 1 | Request to the core (valid) |
| irq_vector | output | 5 | Vector of the winning source |
| irq_prio | output | 4 | Priority of the winning source |
| ack | input | 1 | Acknowledge (ready) |
| eoi | input | 1 | End-of-interrupt pulse |
| cur_mask | output | 4 | Current priority mask |

## Verification
The assertions check on every cycle that a raised `irq` has a nonzero priority above the mask and a valid vector. They also check that a transfer loads the served priority into the mask, that an `ack` with no request and no other strobe leaves the mask unchanged, and that set pulses always leave their software requests pending. Other behaviour depends on history and cannot be checked cycle by cycle: tie-breaking by index, the order of LIFO pops, the discarded push on overflow, the empty-pop rule and the precedence among simultaneous strobes. Only the bench's scenarios, with expected values worked out from the requirements, can show these.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_HW      = 16;
  localparam int NUM_SW      = 8;
  localparam int PRIO_W      = 4;
  localparam int STACK_DEPTH = 8;
  localparam int NUM_SRC     = NUM_HW + NUM_SW;
  localparam int VEC_W       = $clog2(NUM_SRC);
endpackage

// File: rtl/irq_src_table.sv
module irq_src_table
  import irq_pkg::*;
#(
  parameter int N_HW = NUM_HW,
  parameter int N_SW = NUM_SW,
  parameter int PW   = PRIO_W,
  localparam int NS  = N_HW + N_SW,
  localparam int VW  = $clog2(NS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [VW-1:0]    cfg_src,
  input  logic [PW-1:0]    cfg_prio,
  input  logic [N_SW-1:0]  sw_set,
  input  logic [N_SW-1:0]  sw_clr,
  output logic [NS*PW-1:0] prio_flat,
  output logic [N_SW-1:0]  sw_pend
);
  // one priority register per source
  for (genvar g = 0; g < NS; g++) begin : g_prio
    logic [PW-1:0] p_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        p_q <= '0;
      else if (cfg_we && (int'(cfg_src) == g))
        p_q <= cfg_prio;
    end
    assign prio_flat[g*PW +: PW] = p_q;
  end

  // software requests: set has precedence over clear
  always_ff @(posedge clk) begin
    if (!rst_n)
      sw_pend <= '0;
    else
      sw_pend <= (sw_pend & ~sw_clr) | sw_set;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NS = NUM_SRC,
  parameter int PW = PRIO_W,
  localparam int VW = $clog2(NS)
) (
  input  logic [NS-1:0]    req,
  input  logic [NS*PW-1:0] prio_flat,
  output logic [PW-1:0]    best_prio,
  output logic [VW-1:0]    best_vec
);
  logic [PW-1:0] prio_a [NS];

  for (genvar g = 0; g < NS; g++) begin : g_unpack
    assign prio_a[g] = prio_flat[g*PW +: PW];
  end

  // scan upward and replace only on strictly greater, so lower index wins ties
  always_comb begin
    best_prio = '0;
    best_vec  = '0;
    for (int i = 0; i < NS; i++) begin
      if (req[i] && (prio_a[i] > best_prio)) begin
        best_prio = prio_a[i];
        best_vec  = VW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack
  import irq_pkg::*;
#(
  parameter int PW    = PRIO_W,
  parameter int DEPTH = STACK_DEPTH,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [PW-1:0] push_mask,
  input  logic          pop,
  input  logic          mask_we,
  input  logic [PW-1:0] mask_wdata,
  output logic [PW-1:0] cur_mask
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [PW-1:0] mem [DEPTH];
  logic [CW-1:0] depth_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_mask <= '0;
      depth_q  <= '0;
    end else if (push) begin
      cur_mask <= push_mask;
      if (depth_q != FULL) begin
        mem[depth_q[$clog2(DEPTH)-1:0]] <= cur_mask;
        depth_q <= depth_q + 1'b1;
      end
    end else if (pop) begin
      if (depth_q != '0) begin
        cur_mask <= mem[$clog2(DEPTH)'(depth_q - 1'b1)];
        depth_q  <= depth_q - 1'b1;
      end else begin
        cur_mask <= '0;
      end
    end else if (mask_we) begin
      cur_mask <= mask_wdata;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_HW  = NUM_HW,
  parameter int N_SW  = NUM_SW,
  parameter int PW    = PRIO_W,
  parameter int DEPTH = STACK_DEPTH,
  localparam int NS   = N_HW + N_SW,
  localparam int VW   = $clog2(NS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_HW-1:0] hw_req,
  input  logic [N_SW-1:0] sw_set,
  input  logic [N_SW-1:0] sw_clr,
  input  logic            cfg_we,
  input  logic [VW-1:0]   cfg_src,
  input  logic [PW-1:0]   cfg_prio,
  input  logic            mask_we,
  input  logic [PW-1:0]   mask_wdata,
  output logic            irq,
  output logic [VW-1:0]   irq_vector,
  output logic [PW-1:0]   irq_prio,
  input  logic            ack,
  input  logic            eoi,
  output logic [PW-1:0]   cur_mask
);
  logic [NS*PW-1:0] prio_flat;
  logic [N_SW-1:0]  sw_pend;
  logic [PW-1:0]    best_prio;
  logic [VW-1:0]    best_vec;
  logic             take;

  irq_src_table #(.N_HW(N_HW), .N_SW(N_SW), .PW(PW)) u_tab (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
    .cfg_prio(cfg_prio), .sw_set(sw_set), .sw_clr(sw_clr),
    .prio_flat(prio_flat), .sw_pend(sw_pend)
  );

  irq_arbiter #(.NS(NS), .PW(PW)) u_arb (
    .req({sw_pend, hw_req}), .prio_flat(prio_flat),
    .best_prio(best_prio), .best_vec(best_vec)
  );

  assign irq        = best_prio > cur_mask;
  assign irq_vector = best_vec;
  assign irq_prio   = best_prio;
  assign take       = ack && irq;

  irq_prio_stack #(.PW(PW), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(take), .push_mask(best_prio),
    .pop(eoi), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .cur_mask(cur_mask)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int NS   = 24,
  parameter int N_SW = 8,
  parameter int PW   = 4,
  localparam int VW  = $clog2(NS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack,
  input logic            eoi,
  input logic            mask_we,
  input logic            irq,
  input logic [VW-1:0]   irq_vector,
  input logic [PW-1:0]   irq_prio,
  input logic [PW-1:0]   cur_mask,
  input logic [N_SW-1:0] sw_set,
  input logic [N_SW-1:0] sw_pend
);
  assert_irq_above_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_prio > cur_mask));
  assert_irq_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_prio != '0));
  assert_vec_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (int'(irq_vector) < NS));
  assert_take_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> (cur_mask == $past(irq_prio)));
  assert_idle_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq && !eoi && !mask_we) |=> $stable(cur_mask));
  assert_sw_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_set != '0) |=> ((sw_pend & $past(sw_set)) == $past(sw_set)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NS(NS), .N_SW(N_SW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .eoi(eoi), .mask_we(mask_we),
  .irq(irq), .irq_vector(irq_vector), .irq_prio(irq_prio),
  .cur_mask(cur_mask), .sw_set(sw_set), .sw_pend(sw_pend)
);

// File: tb/prio_irq_ctrl_test.sv
module prio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] hw_req;
  logic [7:0]  sw_set, sw_clr;
  logic        cfg_we, mask_we, ack, eoi;
  logic [4:0]  cfg_src;
  logic [3:0]  cfg_prio, mask_wdata;
  logic        irq;
  logic [4:0]  irq_vector;
  logic [3:0]  irq_prio, cur_mask;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_set(sw_set), .sw_clr(sw_clr),
    .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_prio(cfg_prio),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .irq(irq),
    .irq_vector(irq_vector), .irq_prio(irq_prio), .ack(ack), .eoi(eoi),
    .cur_mask(cur_mask)
  );

  // {hw_req, sw pending, mask, exp irq, exp vector}
  localparam int NV = 12;
  localparam logic [33:0] TBL [NV] = '{
    {16'h0001, 8'h00, 4'd0,  1'b0, 5'd0},
    {16'h0002, 8'h00, 4'd0,  1'b1, 5'd1},
    {16'h0002, 8'h00, 4'd1,  1'b0, 5'd0},
    {16'h0082, 8'h00, 4'd0,  1'b1, 5'd7},
    {16'h8080, 8'h00, 4'd0,  1'b1, 5'd7},
    {16'h0080, 8'h00, 4'd7,  1'b0, 5'd0},
    {16'h0040, 8'h01, 4'd0,  1'b1, 5'd16},
    {16'h0000, 8'h81, 4'd14, 1'b1, 5'd23},
    {16'h0000, 8'h81, 4'd15, 1'b0, 5'd0},
    {16'h0100, 8'h00, 4'd0,  1'b0, 5'd0},
    {16'h0200, 8'h00, 4'd0,  1'b1, 5'd9},
    {16'hFFFF, 8'h00, 4'd6,  1'b1, 5'd7}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_strobes();
    sw_set = '0; sw_clr = '0; cfg_we = 0; mask_we = 0; ack = 0; eoi = 0;
  endtask

  // strobes set by caller are held over one rising edge, then released
  task automatic pulse();
    @(negedge clk);
    clear_strobes();
    #1;
  endtask

  task automatic set_mask(input int m);
    mask_we = 1; mask_wdata = 4'(m); pulse();
  endtask

  initial begin
    #(20 * 100000);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 0; hw_req = '0; cfg_src = '0; cfg_prio = '0; mask_wdata = '0;
    clear_strobes();
    repeat (3) @(negedge clk);
    rst_n = 1;
    hw_req = 16'hFFFF;
    #1;
    chk("R1 irq after reset", irq, 0);
    chk("R1 mask after reset", cur_mask, 0);
    hw_req = '0;

    // priorities: hw i -> i%8, sw j -> 8+j
    for (int i = 0; i < 24; i++) begin
      cfg_we = 1; cfg_src = 5'(i);
      cfg_prio = (i < 16) ? 4'(i % 8) : 4'(8 + i - 16);
      pulse();
    end

    // R2/R3 vector table
    for (int k = 0; k < NV; k++) begin
      hw_req = TBL[k][33:18];
      sw_set = TBL[k][17:10];
      sw_clr = ~TBL[k][17:10];
      mask_we = 1; mask_wdata = TBL[k][9:6];
      pulse();
      chk($sformatf("R2 irq vec%0d", k), irq, TBL[k][5]);
      if (TBL[k][5]) chk($sformatf("R3 vector vec%0d", k), irq_vector, TBL[k][4:0]);
    end
    hw_req = '0; sw_clr = 8'hFF; pulse();
    set_mask(0);

    // R4: out-of-range index ignored, in-range write takes effect
    cfg_we = 1; cfg_src = 5'd31; cfg_prio = 4'd15; pulse();
    hw_req = 16'h0001; #1;
    chk("R4 out-of-range write", irq, 0);
    cfg_we = 1; cfg_src = 5'd0; cfg_prio = 4'd3; pulse();
    chk("R4 write irq", irq, 1);
    chk("R4 write prio", irq_prio, 3);
    cfg_we = 1; cfg_src = 5'd0; cfg_prio = 4'd0; pulse();
    hw_req = '0;

    // R5 mask write
    set_mask(9);
    chk("R5 mask write", cur_mask, 9);
    set_mask(0);

    // R11 combinational, R6 push, R7 pops
    @(negedge clk); hw_req = 16'h0002; #1;
    chk("R11 same-cycle irq", irq, 1);
    chk("R11 same-cycle vector", irq_vector, 1);
    ack = 1; pulse();
    chk("R6 mask after ack", cur_mask, 1);
    chk("R6 irq masked", irq, 0);
    hw_req = 16'h0082; #1;
    chk("R3 nested vector", irq_vector, 7);
    ack = 1; pulse();
    chk("R6 nested mask", cur_mask, 7);
    hw_req = '0;
    eoi = 1; pulse();
    chk("R7 pop 1", cur_mask, 1);
    eoi = 1; pulse();
    chk("R7 pop 2", cur_mask, 0);
    set_mask(5);
    eoi = 1; pulse();
    chk("R7 empty pop", cur_mask, 0);

    // R6 ack without request
    set_mask(3);
    ack = 1; pulse();
    chk("R6 idle ack", cur_mask, 3);

    // R8 overflow: nine pushes of 0..8, ninth is discarded
    sw_set = 8'h80; pulse();
    for (int k = 0; k < 9; k++) begin
      set_mask(k);
      ack = 1; pulse();
      chk($sformatf("R8 push %0d", k), cur_mask, 15);
    end
    for (int k = 7; k >= 0; k--) begin
      eoi = 1; pulse();
      chk($sformatf("R8 pop to %0d", k), cur_mask, k);
    end
    eoi = 1; pulse();
    chk("R8 dropped entry", cur_mask, 0);

    // R10 precedence
    ack = 1; eoi = 1; pulse();
    chk("R10 ack over eoi", cur_mask, 15);
    eoi = 1; mask_we = 1; mask_wdata = 4'd9; pulse();
    chk("R10 eoi over mask write", cur_mask, 0);
    ack = 1; mask_we = 1; mask_wdata = 4'd4; pulse();
    chk("R10 ack over mask write", cur_mask, 15);
    eoi = 1; pulse();
    chk("R10 pushed old mask", cur_mask, 0);

    // R9 software set/clear
    sw_clr = 8'h80; pulse();
    chk("R9 clear", irq, 0);
    sw_set = 8'h01; sw_clr = 8'h01; pulse();
    chk("R9 set wins", irq, 1);
    chk("R9 set wins vector", irq_vector, 16);
    sw_clr = 8'h01; pulse();
    chk("R9 clear after set", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule